// File: doc/BRIEF.md
# Mask-Based Branch Condition Evaluator

This block decides, for a processor whose jumps all share one opcode, whether the jump in flight is taken. It keeps four comparison flags in a register. The flags are refreshed from a signed comparison of the two operands of the most recent subtract instruction, at the clock edge where that instruction completes. A jump carries a 4-bit requirement mask. The jump is taken only when every flag selected by the mask is true. An empty mask therefore gives an unconditional jump, and combined masks give the strict orderings.

The redirect address is the low bits of the jump's 16-bit immediate, cut to the width of the instruction memory index. The taken decision is combinational from the jump inputs and the registered flags. A flag update and a jump presented in the same cycle leave the jump evaluated against the flags held before that update. Flushing the pipeline after a taken jump is left to the surrounding logic.

Top module: `branch_cond_eval`

## Requirements
- R1: While and after reset, with no update since, the flag register is in the "operands equal" state: eq=1, ge=1, ne=0, le=1.
- R2: On a clock edge with `flag_we` high, the flags are replaced by a signed two's-complement comparison of `opnd_a` against `opnd_b`. The flags are eq (a==b), ge (a>=b), ne (a!=b) and le (a<=b).
- R3: On an edge with `flag_we` low, the flags keep their value.
- R4: The mask bit positions are bit0=eq, bit1=ge, bit2=ne, bit3=le. A mask of 0000 gives `taken`=1 whenever `jmp_valid` is high, whatever the flags.
- R5: With `jmp_valid` high, `taken` is 1 exactly when every flag selected by a 1 in `jmp_mask` is 1.
- R6: `taken` is 0 whenever `jmp_valid` is 0.
- R7: `redirect_pc` equals bits [PC_W-1:0] of `jmp_target`. Higher target bits have no effect.
- R8: A jump presented in the same cycle as a flag update is decided on the flags held before that update.
- R9: Mask 0110 is taken only for a strictly greater signed result, and mask 1100 only for a strictly less one. Across the sign boundary, 0x8000 compares below 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Subtract result completes; capture the comparison flags |
| opnd_a | input | DATA_W | First subtract operand (minuend) |
| opnd_b | input | DATA_W | Second subtract operand (subtrahend) |
| jmp_valid | input | 1 | A jump is being evaluated this cycle |
| jmp_mask | input | 4 | Required-flag mask from the jump's destination field |
| jmp_target | input | DATA_W | Full-width jump immediate |
| taken | output | 1 | Jump condition satisfied |
| redirect_pc | output | PC_W | Truncated jump target |

## Verification
The bench builds the block with its defaults: DATA_W=16 and PC_W=12. At 16 bits, the operand extremes 0x8000 and 0x7FFF can be driven directly, which exposes any comparison done unsigned. It also leaves four target bits above the memory index, so truncation can be observed. Random operand pairs are biased toward equality so that all four flags take both values. Random masks cover all sixteen combinations. Directed cycles pair a flag update with a jump to fix the ordering between them.

// File: rtl/branch_cond_eval.sv
module branch_cond_eval #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              jmp_valid,
  input  logic [3:0]        jmp_mask,
  input  logic [DATA_W-1:0] jmp_target,
  output logic              taken,
  output logic [PC_W-1:0]   redirect_pc
);
  localparam logic [3:0] FLAGS_RST = 4'b1011;

  logic [3:0] flags_q;
  logic       a_eq_b, a_gt_b;
  logic       unused_hi;

  assign a_eq_b = (opnd_a == opnd_b);
  assign a_gt_b = ($signed(opnd_a) > $signed(opnd_b));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flags_q <= FLAGS_RST;
    else if (flag_we) flags_q <= {~a_gt_b, ~a_eq_b, a_gt_b | a_eq_b, a_eq_b};

  assign taken       = jmp_valid && ((jmp_mask & ~flags_q) == 4'b0000);
  assign redirect_pc = jmp_target[PC_W-1:0];
  assign unused_hi   = ^jmp_target[DATA_W-1:PC_W];
endmodule

module branch_cond_eval_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_we,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              jmp_valid,
  input logic [3:0]        jmp_mask,
  input logic              taken
);
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_valid |-> !taken);

  assert_uncond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_valid && jmp_mask == 4'b0000) |-> taken);

  assert_capture_eq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flag_we) && $past(opnd_a == opnd_b) &&
     jmp_valid && jmp_mask == 4'b0001) |-> taken);

  assert_capture_ne_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flag_we) && $past(opnd_a != opnd_b) &&
     jmp_valid && jmp_mask == 4'b0001) |-> !taken);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flag_we) && $past(jmp_valid) && jmp_valid &&
     $stable(jmp_mask)) |-> (taken == $past(taken)));
endmodule

bind branch_cond_eval branch_cond_eval_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .opnd_a(opnd_a),
  .opnd_b(opnd_b), .jmp_valid(jmp_valid), .jmp_mask(jmp_mask), .taken(taken)
);

// File: tb/branch_cond_eval_tb.sv
module branch_cond_eval_tb;
  localparam int DATA_W = 16;
  localparam int PC_W   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flag_we = 1'b0;
  logic [DATA_W-1:0] opnd_a = '0, opnd_b = '0;
  logic              jmp_valid = 1'b0;
  logic [3:0]        jmp_mask = '0;
  logic [DATA_W-1:0] jmp_target = '0;
  logic              taken;
  logic [PC_W-1:0]   redirect_pc;

  int checks = 0, failures = 0;
  logic [3:0] mflags;
  bit done = 0;

  always #4 clk = ~clk;

  branch_cond_eval #(.DATA_W(DATA_W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .jmp_valid(jmp_valid), .jmp_mask(jmp_mask),
    .jmp_target(jmp_target), .taken(taken), .redirect_pc(redirect_pc)
  );

  function automatic logic [3:0] cmp_flags(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    return {sa <= sb, sa != sb, sa >= sb, sa == sb};
  endfunction

  function automatic logic exp_taken(logic v, logic [3:0] m, logic [3:0] f);
    if (!v) return 1'b0;
    for (int i = 0; i < 4; i++)
      if (m[i] && !f[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic fw, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                      logic v, logic [3:0] m, logic [DATA_W-1:0] t);
    @(negedge clk);
    flag_we = fw; opnd_a = a; opnd_b = b;
    jmp_valid = v; jmp_mask = m; jmp_target = t;
    #2;
    check({req, " taken"}, {31'd0, taken}, {31'd0, exp_taken(v, m, mflags)});
    check("R7 redirect", {20'd0, redirect_pc}, {20'd0, t[PC_W-1:0]});
    if (fw) mflags = cmp_flags(a, b);
  endtask

  initial begin
    void'($urandom(32'd1234));
    mflags = 4'b1011;
    #10;
    jmp_valid = 1'b1; jmp_mask = 4'b0001; #1;
    check("R1 reset eq", {31'd0, taken}, 32'd1);
    jmp_mask = 4'b0100; #1;
    check("R1 reset ne", {31'd0, taken}, 32'd0);
    jmp_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step("R1 after reset le", 0, 0, 0, 1, 4'b1000, 16'h0000);
    step("R4 uncond", 0, 0, 0, 1, 4'b0000, 16'hF123);
    step("R6 no valid", 0, 0, 0, 0, 4'b0000, 16'h0ABC);
    step("R2 load gt", 1, 16'd5, 16'd3, 0, 4'b0000, 16'h0000);
    step("R9 bgt", 0, 0, 0, 1, 4'b0110, 16'h0100);
    step("R9 blt", 0, 0, 0, 1, 4'b1100, 16'h0100);
    step("R8 same cycle old", 1, 16'h8000, 16'h7FFF, 1, 4'b0110, 16'h1234);
    step("R9 signed blt", 0, 0, 0, 1, 4'b1100, 16'h0200);
    step("R9 signed bgt", 0, 0, 0, 1, 4'b0110, 16'h0200);
    step("R3 hold", 0, 16'd9, 16'd9, 1, 4'b1100, 16'hFFFF);
    step("R4 uncond flags lt", 0, 0, 0, 1, 4'b0000, 16'hE000);
    step("R2 load eq", 1, 16'h7FFF, 16'h7FFF, 1, 4'b0001, 16'h0001);
    step("R2 eq check", 0, 0, 0, 1, 4'b0001, 16'h0002);
    step("R5 all bits", 0, 0, 0, 1, 4'b1111, 16'h0003);
    for (int n = 0; n < 400; n++) begin
      logic [DATA_W-1:0] a, b;
      a = DATA_W'($urandom);
      b = ($urandom_range(0, 3) == 0) ? a : DATA_W'($urandom);
      step("R5 random", 1'($urandom), a, b, 1'($urandom_range(0, 7) != 0),
           4'($urandom), DATA_W'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule